// File: doc/BRIEF.md
# Bus-Cycle Breakpoint Match Unit

This block watches every CPU bus cycle and compares it against two programmable breakpoint conditions. Each condition names an 8-bit address-space identifier, a target address with a selectable number of ignored low bits, an access kind (instruction fetch or operand access), a direction and an operand size. The size may also be left out of the condition. The second channel can also compare the data on the bus against a value under a bit mask. When a bus cycle meets a channel's condition, a one-cycle match pulse for that channel appears on the next clock. A combined break request appears on the same clock.

Software programs the conditions through a simple write port that selects one of seven registers. Each channel also has a sticky flag that records that it fired. A write of zero to the flag's bit in the status register clears it. The two channels are evaluated independently, and either one alone can raise the break request.

Top module: `bkpt_match_unit`

## Requirements
- R1: A channel fires only when the cycle's ASID equals the channel's 8-bit ASID field (control bits [7:0]).
- R2: The kind field (control bits [11:10]) takes four values: 0 accepts any cycle, 1 only instruction fetches, 2 only operand accesses, and 3 never matches.
- R3: The direction field (control bits [13:12]) takes four values: 0 accepts any direction, 1 only reads, 2 only writes, and 3 never matches. A fetch always counts as a read, so a fetch-plus-write condition never fires, even if `bus_is_write` is high during a fetch.
- R4: The size field (control bits [15:14]) takes four values: 0 leaves size out of the condition, and 1, 2 and 3 require a byte, word or longword access. The bus reports these sizes as `bus_size` codes 0, 1 and 2.
- R5: When size is left out, a longword access matches if its 4-byte-aligned address covers the target. Word and byte accesses must match the target address exactly, so a fetch breakpoint at an odd address never fires.
- R6: The address-mask field (control bits [9:8]) sets how many low address bits are ignored: code 0 ignores none, code 1 the low 10 bits, code 2 the low 12 bits, and code 3 every address bit.
- R7: When the data-compare enable (control bit 16, channel B only) is set, channel B also needs the bus data to equal its data register. Bits set in the data mask are ignored. Only the low 8 bits take part for a byte access, and only the low 16 bits for a word access.
- R8: Each channel fires regardless of the other. `brk_req` is high exactly when either match pulse is high.
- R9: Match pulses and `brk_req` are registered. They are high for one cycle, on the clock after a valid matching cycle, and never after a cycle with `bus_valid` low.
- R10: A sticky flag is set with its channel's match pulse. Writing the status register (select 6) clears flag A if bit 0 is 0 and flag B if bit 1 is 0. A 1 in a bit leaves that flag unchanged.
- R11: A channel fires only while its armed bit (control bit 17) is set. Reset clears every register, pulse and flag.
- R12: Register selects: 0 is the channel A address, 1 the channel A control, 2 the channel B address, 3 the channel B control, 4 the channel B data and 5 the channel B data mask. A write takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Cycle address |
| bus_asid | input | 8 | Cycle address-space identifier |
| bus_is_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| bus_is_write | input | 1 | 1 = write |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| bus_data | input | 32 | Cycle data |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| hit_a | output | 1 | Channel A match pulse |
| hit_b | output | 1 | Channel B match pulse |
| brk_req | output | 1 | Combined break request |
| sticky_a | output | 1 | Channel A sticky flag |
| sticky_b | output | 1 | Channel B sticky flag |

## Verification
The bench targets the footprint rule with these cases:
- A longword read two bytes below the target must hit.
- A byte one byte above the target must not hit.
- A longword just past the target must not hit.
A design that compared whole addresses for every size, or that aligned every access, would get one of these cases wrong.

The 4 KB mask window is probed at both of its ends and just outside them, to catch an off-by-one in the mask width. A fetch is driven with the write line high, to catch a design that trusts that line during a fetch. The data compare is checked with corrupted upper bits on a word write, which a design comparing full width would reject. It is also checked under a partial mask. Sticky flags are cleared one at a time, so that a design clearing both flags on any status write is caught.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} bus_size_e;

  // condition fields above the ASID byte of a control word
  typedef struct packed {
    logic       armed;
    logic       den;
    logic [1:0] size_c;
    logic [1:0] dir_c;
    logic [1:0] kind_c;
    logic [1:0] mask_c;
  } cond_ctl_t;

  localparam int CTL_W    = $bits(cond_ctl_t);
  localparam int SEL_DVAL = 4;
  localparam int SEL_DMSK = 5;
  localparam int SEL_STAT = 6;
endpackage

// File: rtl/bkpt_cond_regs.sv
module bkpt_cond_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] t_addr [NCH],
  output logic [ASID_W-1:0] t_asid [NCH],
  output cond_ctl_t         t_ctl  [NCH],
  output logic [DATA_W-1:0] t_dval,
  output logic [DATA_W-1:0] t_dmask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        t_addr[c] <= '0;
        t_asid[c] <= '0;
        t_ctl[c]  <= '0;
      end
      t_dval  <= '0;
      t_dmask <= '0;
    end else if (cfg_we) begin
      for (int c = 0; c < NCH; c++) begin
        if (cfg_sel == SEL_W'(2 * c))
          t_addr[c] <= cfg_wdata[ADDR_W-1:0];
        if (cfg_sel == SEL_W'(2 * c + 1)) begin
          t_asid[c] <= cfg_wdata[ASID_W-1:0];
          t_ctl[c]  <= cfg_wdata[ASID_W +: CTL_W];
        end
      end
      if (cfg_sel == SEL_W'(SEL_DVAL)) t_dval  <= cfg_wdata;
      if (cfg_sel == SEL_W'(SEL_DMSK)) t_dmask <= cfg_wdata;
    end
  end
endmodule

// File: rtl/bkpt_chan_cmp.sv
module bkpt_chan_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ASID_W   = 8,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ASID_W-1:0] bus_asid,
  input  logic              bus_is_fetch,
  input  logic              bus_is_write,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] t_addr,
  input  logic [ASID_W-1:0] t_asid,
  input  cond_ctl_t         t_ctl,
  input  logic [DATA_W-1:0] t_dval,
  input  logic [DATA_W-1:0] t_dmask,
  output logic              match
);
  localparam logic [ADDR_W-1:0] KEEP_ALL = '1;
  localparam logic [ADDR_W-1:0] DROP10   = KEEP_ALL << 10;
  localparam logic [ADDR_W-1:0] DROP12   = KEEP_ALL << 12;
  localparam logic [ADDR_W-1:0] DROP2    = KEEP_ALL << 2;

  logic [ADDR_W-1:0] amask;
  logic asid_ok, kind_ok, dir_ok, size_ok, addr_ok, data_ok, eff_wr;

  always_comb begin
    unique case (t_ctl.mask_c)
      2'd0:    amask = KEEP_ALL;
      2'd1:    amask = DROP10;
      2'd2:    amask = DROP12;
      default: amask = '0;
    endcase
    // size left out: a longword covering the target matches
    if (t_ctl.size_c == 2'd0 && bus_size == SZ_LONG)
      amask = amask & DROP2;
  end

  assign eff_wr  = bus_is_write & ~bus_is_fetch;
  assign asid_ok = (bus_asid == t_asid);
  assign addr_ok = ((bus_addr ^ t_addr) & amask) == '0;
  assign size_ok = (t_ctl.size_c == 2'd0) || (bus_size == t_ctl.size_c - 2'd1);

  always_comb begin
    unique case (t_ctl.kind_c)
      2'd0:    kind_ok = 1'b1;
      2'd1:    kind_ok = bus_is_fetch;
      2'd2:    kind_ok = ~bus_is_fetch;
      default: kind_ok = 1'b0;
    endcase
    unique case (t_ctl.dir_c)
      2'd0:    dir_ok = 1'b1;
      2'd1:    dir_ok = ~eff_wr;
      2'd2:    dir_ok = eff_wr;
      default: dir_ok = 1'b0;
    endcase
  end

  generate
    if (HAS_DATA) begin : g_data
      logic [DATA_W-1:0] wmask;
      always_comb begin
        unique case (bus_size)
          SZ_BYTE: wmask = DATA_W'(8'hFF);
          SZ_WORD: wmask = DATA_W'(16'hFFFF);
          default: wmask = '1;
        endcase
      end
      assign data_ok = ~t_ctl.den | (((bus_data ^ t_dval) & ~t_dmask & wmask) == '0);
    end else begin : g_nodata
      assign data_ok = 1'b1;
    end
  endgenerate

  assign match = t_ctl.armed & asid_ok & kind_ok & dir_ok & size_ok & addr_ok & data_ok;
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ASID_W-1:0] bus_asid,
  input  logic              bus_is_fetch,
  input  logic              bus_is_write,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              hit_a,
  output logic              hit_b,
  output logic              brk_req,
  output logic              sticky_a,
  output logic              sticky_b
);
  logic [ADDR_W-1:0] t_addr [NCH];
  logic [ASID_W-1:0] t_asid [NCH];
  cond_ctl_t         t_ctl  [NCH];
  logic [DATA_W-1:0] t_dval, t_dmask;
  logic [NCH-1:0]    match, hit_q, sticky_q, clr;

  bkpt_cond_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .t_addr(t_addr), .t_asid(t_asid), .t_ctl(t_ctl), .t_dval(t_dval), .t_dmask(t_dmask)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      bkpt_chan_cmp #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W), .HAS_DATA(c == NCH - 1)
      ) u_cmp (
        .bus_addr(bus_addr), .bus_asid(bus_asid), .bus_is_fetch(bus_is_fetch),
        .bus_is_write(bus_is_write), .bus_size(bus_size), .bus_data(bus_data),
        .t_addr(t_addr[c]), .t_asid(t_asid[c]), .t_ctl(t_ctl[c]),
        .t_dval(t_dval), .t_dmask(t_dmask), .match(match[c])
      );
      assign clr[c] = cfg_we && (cfg_sel == SEL_W'(SEL_STAT)) && !cfg_wdata[c];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q    <= '0;
      sticky_q <= '0;
      brk_req  <= 1'b0;
    end else begin
      hit_q    <= bus_valid ? match : '0;
      brk_req  <= bus_valid && (match != '0);
      sticky_q <= (sticky_q & ~clr) | (bus_valid ? match : '0);
    end
  end

  assign hit_a    = hit_q[0];
  assign hit_b    = hit_q[1];
  assign sticky_a = sticky_q[0];
  assign sticky_b = sticky_q[1];
endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk
  import bkpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              cfg_we,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              hit_a,
  input logic              hit_b,
  input logic              brk_req,
  input logic              sticky_a,
  input logic              sticky_b
);
  // R9
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (!hit_a && !hit_b && !brk_req));
  // R8
  hit_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_a || hit_b) |-> brk_req);
  // R8
  req_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (hit_a || hit_b));
  // R10
  sticky_a_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit_a |-> sticky_a);
  // R10
  sticky_b_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit_b |-> sticky_b);
  // R10
  sticky_a_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sticky_a) |-> $past(cfg_we && cfg_sel == SEL_W'(SEL_STAT) && !cfg_wdata[0]));
  // R10
  sticky_b_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sticky_b) |-> $past(cfg_we && cfg_sel == SEL_W'(SEL_STAT) && !cfg_wdata[1]));
endmodule

bind bkpt_match_unit bkpt_match_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .hit_a(hit_a), .hit_b(hit_b), .brk_req(brk_req),
  .sticky_a(sticky_a), .sticky_b(sticky_b)
);

// File: tb/bkpt_match_unit_bench.sv
`timescale 1ns/1ps
module bkpt_match_unit_bench;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_valid = 0, bus_is_fetch = 0, bus_is_write = 0;
  logic [31:0] bus_addr = 0, bus_data = 0, cfg_wdata = 0;
  logic [7:0]  bus_asid = 0;
  logic [1:0]  bus_size = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic        hit_a, hit_b, brk_req, sticky_a, sticky_b;

  int checks = 0, failures = 0;
  bit done = 0;
  string phase = "R11";

  // reference model state
  logic [31:0] m_addr [2], m_ctl [2];
  logic [31:0] m_dval, m_dmask;
  bit e_a, e_b, e_sa, e_sb;

  always #4 clk = ~clk;

  bkpt_match_unit u_bkpt_match_unit (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_asid(bus_asid),
    .bus_is_fetch(bus_is_fetch), .bus_is_write(bus_is_write), .bus_size(bus_size),
    .bus_data(bus_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hit_a(hit_a), .hit_b(hit_b), .brk_req(brk_req), .sticky_a(sticky_a), .sticky_b(sticky_b)
  );

  function automatic bit model_match(int c);
    logic [31:0] w = m_ctl[c];
    int ign, width;
    bit wr;
    if (!w[17]) return 0;
    if (bus_asid != w[7:0]) return 0;
    if (w[11:10] == 1 && !bus_is_fetch) return 0;
    if (w[11:10] == 2 && bus_is_fetch) return 0;
    if (w[11:10] == 3) return 0;
    wr = bus_is_write && !bus_is_fetch;
    if (w[13:12] == 1 && wr) return 0;
    if (w[13:12] == 2 && !wr) return 0;
    if (w[13:12] == 3) return 0;
    if (w[15:14] != 0 && int'(bus_size) != int'(w[15:14]) - 1) return 0;
    case (w[9:8]) 0: ign = 0; 1: ign = 10; 2: ign = 12; default: ign = 32; endcase
    if (w[15:14] == 0 && bus_size == 2 && ign < 2) ign = 2;
    if (ign < 32 && (bus_addr >> ign) != (m_addr[c] >> ign)) return 0;
    if (c == 1 && w[16]) begin
      width = (bus_size == 0) ? 8 : (bus_size == 1) ? 16 : 32;
      for (int k = 0; k < width; k++)
        if (!m_dmask[k] && bus_data[k] != m_dval[k]) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    bit ma, mb;
    if (rst) begin
      e_a = 0; e_b = 0; e_sa = 0; e_sb = 0;
      m_addr[0] = 0; m_addr[1] = 0; m_ctl[0] = 0; m_ctl[1] = 0; m_dval = 0; m_dmask = 0;
    end else begin
      ma = bus_valid && model_match(0);
      mb = bus_valid && model_match(1);
      e_a = ma; e_b = mb;
      if (cfg_we && cfg_sel == 6) begin
        if (!cfg_wdata[0]) e_sa = 0;
        if (!cfg_wdata[1]) e_sb = 0;
      end
      e_sa = e_sa | ma; e_sb = e_sb | mb;
      if (cfg_we) case (cfg_sel)
        0: m_addr[0] = cfg_wdata; 1: m_ctl[0] = cfg_wdata;
        2: m_addr[1] = cfg_wdata; 3: m_ctl[1] = cfg_wdata;
        4: m_dval = cfg_wdata;    5: m_dmask = cfg_wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) if (!rst && !done) begin
    chk(phase, "model hit_a", hit_a, e_a);
    chk(phase, "model hit_b", hit_b, e_b);
    chk("R8", "model brk_req", brk_req, e_a | e_b);
    chk(phase, "model sticky_a", sticky_a, e_sa);
    chk(phase, "model sticky_b", sticky_b, e_sb);
  end

  function automatic logic [31:0] ctlw(bit armed, bit den, int sz, int dir, int kind, int msk,
                                       logic [7:0] asid);
    return {14'd0, armed, den, 2'(sz), 2'(dir), 2'(kind), 2'(msk), asid};
  endfunction

  task automatic wr(int sel, logic [31:0] d);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic probe(string req, logic [31:0] a, logic [7:0] asid, bit f, bit w, int sz,
                       logic [31:0] d, bit ea, bit eb);
    bus_valid = 1; bus_addr = a; bus_asid = asid; bus_is_fetch = f; bus_is_write = w;
    bus_size = 2'(sz); bus_data = d;
    @(negedge clk);
    bus_valid = 0;
    chk(req, "probe hit_a", hit_a, ea);
    chk(req, "probe hit_b", hit_b, eb);
    chk(req, "probe brk_req", brk_req, ea | eb);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state, and an unarmed channel matching address 0 does not fire
    chk("R11", "reset sticky_a", sticky_a, 0);
    probe("R11", 32'h0, 8'h00, 0, 0, 1, 0, 0, 0);

    // channel A: operand read at 0x123456, ASID 0x80, size left out (R12 map)
    phase = "R5";
    wr(0, 32'h0012_3456);
    wr(1, ctlw(1, 0, 0, 1, 2, 0, 8'h80));
    probe("R5", 32'h0012_3454, 8'h80, 0, 0, 2, 0, 1, 0);
    probe("R5", 32'h0012_3456, 8'h80, 0, 0, 1, 0, 1, 0);
    probe("R5", 32'h0012_3456, 8'h80, 0, 0, 0, 0, 1, 0);
    probe("R5", 32'h0012_3457, 8'h80, 0, 0, 0, 0, 0, 0);
    probe("R5", 32'h0012_3458, 8'h80, 0, 0, 2, 0, 0, 0);
    probe("R3", 32'h0012_3456, 8'h80, 0, 1, 1, 0, 0, 0);
    probe("R1", 32'h0012_3456, 8'h81, 0, 0, 1, 0, 0, 0);
    probe("R2", 32'h0012_3456, 8'h80, 1, 0, 1, 0, 0, 0);
    // R9: single-cycle pulse
    chk("R9", "pulse gone", hit_a, 0);

    // channel B: operand word write of 0xA512 in the 4 KB block, ASID 0x70
    phase = "R6";
    wr(2, 32'h000A_BCDE);
    wr(3, ctlw(1, 1, 2, 2, 2, 2, 8'h70));
    wr(4, 32'h0000_A512);
    wr(5, 32'h0);
    probe("R6", 32'h000A_B000, 8'h70, 0, 1, 1, 32'h0000_A512, 0, 1);
    probe("R6", 32'h000A_BFFE, 8'h70, 0, 1, 1, 32'h0000_A512, 0, 1);
    probe("R6", 32'h000A_C000, 8'h70, 0, 1, 1, 32'h0000_A512, 0, 0);
    probe("R6", 32'h000A_AFFE, 8'h70, 0, 1, 1, 32'h0000_A512, 0, 0);
    phase = "R7";
    probe("R7", 32'h000A_B100, 8'h70, 0, 1, 1, 32'h0000_A513, 0, 0);
    probe("R7", 32'h000A_B100, 8'h70, 0, 1, 1, 32'hFFFF_A512, 0, 1);
    wr(5, 32'h0000_000F);
    probe("R7", 32'h000A_B100, 8'h70, 0, 1, 1, 32'h0000_A51F, 0, 1);
    probe("R7", 32'h000A_B100, 8'h70, 0, 1, 1, 32'h0000_B512, 0, 0);
    phase = "R4";
    probe("R4", 32'h000A_B100, 8'h70, 0, 1, 0, 32'h0000_0012, 0, 0);
    probe("R4", 32'h000A_B100, 8'h70, 0, 0, 1, 32'h0000_A512, 0, 0);

    // R8: both channels in one cycle, each independently
    phase = "R8";
    wr(1, ctlw(1, 0, 0, 0, 0, 3, 8'h70));
    probe("R8", 32'h000A_B200, 8'h70, 0, 1, 1, 32'h0000_A512, 1, 1);
    probe("R6", 32'h1234_5678, 8'h70, 0, 0, 2, 0, 1, 0);
    wr(1, ctlw(1, 0, 0, 0, 0, 1, 8'h70));
    probe("R6", 32'h0000_13FF, 8'h70, 0, 0, 0, 0, 0, 0);
    wr(0, 32'h0000_1000);
    probe("R6", 32'h0000_13FF, 8'h70, 0, 0, 0, 0, 1, 0);
    probe("R6", 32'h0000_1400, 8'h70, 0, 0, 0, 0, 0, 0);

    // R10: clear sticky flags one at a time
    phase = "R10";
    wr(6, 32'h2);
    chk("R10", "sticky_a cleared", sticky_a, 0);
    chk("R10", "sticky_b kept", sticky_b, 1);
    wr(6, 32'h3);
    chk("R10", "sticky_b kept by 1", sticky_b, 1);
    wr(6, 32'h0);
    chk("R10", "sticky_b cleared", sticky_b, 0);

    // R3/R2: fetch plus write never fires; fetch with direction any does
    phase = "R3";
    wr(0, 32'h0002_7128);
    wr(1, ctlw(1, 0, 2, 2, 1, 0, 8'h80));
    probe("R3", 32'h0002_7128, 8'h80, 1, 1, 1, 0, 0, 0);
    phase = "R2";
    wr(1, ctlw(1, 0, 0, 0, 1, 0, 8'h80));
    probe("R2", 32'h0002_7128, 8'h80, 1, 1, 1, 0, 1, 0);
    probe("R2", 32'h0002_7128, 8'h80, 0, 0, 1, 0, 0, 0);
    wr(1, ctlw(1, 0, 0, 0, 3, 0, 8'h80));
    probe("R2", 32'h0002_7128, 8'h80, 1, 0, 1, 0, 0, 0);

    // R5: fetch breakpoint at an odd address
    phase = "R5";
    wr(2, 32'h0003_1415);
    wr(3, ctlw(1, 0, 0, 1, 1, 0, 8'h70));
    probe("R5", 32'h0003_1414, 8'h70, 1, 0, 1, 0, 0, 0);
    probe("R5", 32'h0003_1416, 8'h70, 1, 0, 1, 0, 0, 0);

    // R11: disarm
    phase = "R11";
    wr(3, ctlw(0, 0, 0, 0, 0, 3, 8'h70));
    probe("R11", 32'h0003_1415, 8'h70, 0, 0, 0, 0, 0, 0);

    // R9: valid low with matching fields gives nothing
    phase = "R9";
    wr(1, ctlw(1, 0, 0, 0, 0, 3, 8'h00));
    bus_asid = 0; bus_valid = 0;
    @(negedge clk);
    chk("R9", "idle hit_a", hit_a, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule